// File: doc/BRIEF.md
# Page Write Buffer with Deferred Commit

This block sits between a serial command front end and a byte-wide nonvolatile array model. At the start of a write frame the front end hands over the target address. The page number is held. The low address bits give the first slot inside a page of `PAGE_BYTES` bytes. Each payload byte is placed at the current slot, and the slot pointer then advances with wrap-around inside the page, so a long payload folds back over earlier slots. Nothing reaches the array while the frame is being loaded.

When chip select rises, the front end reports the end of the frame. It also reports whether the frame ended on a whole byte, and a permit bit from the protection logic. The frame is committed only if it ended on a byte boundary, writing is permitted and at least one byte was loaded. In that case the block walks the slots in ascending order and issues one array write per loaded slot. It then holds `busy` for a self-timed settle interval of `BUSY_CYCLES` clocks. On the last busy cycle it pulses `wen_clear`, which tells the protection logic to drop its write-enable latch. While `busy` is high, new frames, payload bytes and frame ends are all ignored.

Top module: `pwb_page_commit`

## Requirements
- R1: After reset, `busy`, `arr_we` and `wen_clear` are all 0.
- R2: A byte loaded as the n-th byte (counting from 0) of a frame goes to slot `(start_addr[4:0] + n) mod 32`. The slot wraps within the page. The committed address is `{start_addr[ADDR_W-1:5], slot}`.
- R3: When more than 32 bytes are loaded, each slot is committed once, holding the last byte loaded into it.
- R4: Only slots loaded in the frame are written. The writes come one per cycle in ascending slot order, from slot 0 to slot 31, and slots that were not loaded are skipped.
- R5: A frame end with `frame_aligned` = 0 cancels the write. No array write occurs and `busy` stays 0.
- R6: A frame end with `permit` = 0 cancels the write. No array write occurs and `busy` stays 0.
- R7: After an accepted frame end, `busy` rises on the next cycle and stays high for exactly `PAGE_BYTES + BUSY_CYCLES` cycles. `arr_we` is only ever high while `busy` is high.
- R8: `wen_clear` is a single-cycle pulse on the last cycle of a busy interval. It occurs only then.
- R9: Frame starts, payload bytes and frame ends that arrive while `busy` is high are ignored. They cause no array write, either then or later.
- R10: A frame end after a frame with no payload bytes causes no array write and leaves `busy` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Frame start: capture `start_addr` and clear the buffer |
| start_addr | input | ADDR_W | Write start address (page number and first slot) |
| byte_valid | input | 1 | One payload byte is present on `byte_data` |
| byte_data | input | DATA_W | Payload byte |
| frame_end | input | 1 | Chip-select rise event, one cycle |
| frame_aligned | input | 1 | Frame ended on a whole byte (valid with `frame_end`) |
| permit | input | 1 | Write allowed by protection logic (valid with `frame_end`) |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Commit and settle interval in progress |
| wen_clear | output | 1 | Pulse: clear the write-enable latch |

## Verification
On every cycle the assertions check the relations between ports. Array writes only happen while busy, and consecutive writes climb in slot order. Busy only rises after a frame end that was aligned and permitted. Misaligned or refused frame ends keep an idle block idle, and the enable-clear pulse sits at the fall of busy. Whether the right bytes land at the right addresses cannot be seen by those properties: in-page wrap, last-writer-wins on overflow, skipping of unloaded slots, and rejection of traffic during busy. Those are shown by the scoreboard scenarios, which predict every array write from the frame contents and measure the exact busy length.

// File: rtl/pwb_pkg.sv
// Package: shared types for the page write buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package pwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_SETTLE = 2'd2
    } pwb_state_e;
endpackage

// File: rtl/pwb_page_buffer.sv
// Module: pwb_page_buffer
// Holds one page of payload bytes plus a per-slot loaded mask.
// A clear re-seeds the slot pointer and empties the mask. Each load
// writes the pointed slot and advances the pointer modulo the page.
// Assumes: PAGE_BYTES is a power of two, so that the pointer wraps naturally.
module pwb_page_buffer #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    localparam int SLOT_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [SLOT_W-1:0] base_slot,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_loaded,
    output logic              any_loaded
);

    logic [SLOT_W-1:0]     ptr_q;
    logic [PAGE_BYTES-1:0] mask_q;
    logic [DATA_W-1:0]     data_q [PAGE_BYTES];

    // Slot pointer: re-seeded by clear, advanced with in-page wrap on load.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (clear)  ptr_q <= base_slot;
        else if (load)   ptr_q <= ptr_q + 1'b1;
    end

    // Page storage and mask: a later byte into a slot overwrites an earlier one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            for (int s = 0; s < PAGE_BYTES; s++) data_q[s] <= '0;
        end else if (clear) begin
            mask_q <= '0;
        end else if (load) begin
            data_q[ptr_q] <= load_data;
            mask_q[ptr_q] <= 1'b1;
        end
    end

    // Read port for the commit scan.
    always_comb begin
        rd_data    = data_q[rd_slot];
        rd_loaded  = mask_q[rd_slot];
        any_loaded = |mask_q;
    end

endmodule

// File: rtl/pwb_commit_ctrl.sv
// Module: pwb_commit_ctrl
// Gates frame traffic, decides on commit at frame end, scans all slots
// once (one per cycle), then counts out the settle interval.
// Assumes: BUSY_CYCLES >= 1. A frame start precedes its payload bytes.
// A frame end comes at least one cycle after the last byte.
module pwb_commit_ctrl
    import pwb_pkg::*;
#(
    parameter int PAGE_BYTES  = 32,
    parameter int BUSY_CYCLES = 100,
    localparam int SLOT_W     = $clog2(PAGE_BYTES),
    localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic              byte_valid,
    input  logic              frame_end,
    input  logic              frame_aligned,
    input  logic              permit,
    input  logic              any_loaded,
    input  logic              rd_loaded,
    output logic              take_start,
    output logic              take_byte,
    output logic [SLOT_W-1:0] scan_slot,
    output logic              arr_we,
    output logic              busy,
    output logic              wen_clear
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PAGE_BYTES - 1);
    localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(BUSY_CYCLES - 1);

    pwb_state_e        state_q;
    logic              open_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              idle;
    logic              accept;

    // Traffic gating: nothing is taken unless idle.
    always_comb begin
        idle       = (state_q == ST_IDLE);
        take_start = idle && start_valid;
        take_byte  = idle && open_q && byte_valid && !start_valid;
        accept     = idle && open_q && frame_end && frame_aligned
                     && permit && any_loaded;
    end

    // Frame-open flag: set by an accepted start, dropped by any idle frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)                  open_q <= 1'b0;
        else if (take_start)         open_q <= 1'b1;
        else if (idle && frame_end)  open_q <= 1'b0;
    end

    // Sequencer: idle -> slot scan -> settle count -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_COMMIT;
                        slot_q  <= '0;
                    end
                end
                ST_COMMIT: begin
                    if (slot_q == LAST_SLOT) begin
                        state_q <= ST_SETTLE;
                        cnt_q   <= '0;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (cnt_q == LAST_CNT) state_q <= ST_IDLE;
                    else                   cnt_q   <= cnt_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from sequencer state.
    always_comb begin
        scan_slot = slot_q;
        arr_we    = (state_q == ST_COMMIT) && rd_loaded;
        busy      = !idle;
        wen_clear = (state_q == ST_SETTLE) && (cnt_q == LAST_CNT);
    end

endmodule

// File: rtl/pwb_page_commit.sv
// Module: pwb_page_commit (top)
// Page write buffer with deferred commit on frame end and a self-timed busy.
// Assumes: the serial front end qualifies frame_end with frame_aligned, and
// the protection block qualifies it with permit, both in the same cycle.
module pwb_page_commit #(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 32,
    parameter int BUSY_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              frame_end,
    input  logic              frame_aligned,
    input  logic              permit,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              busy,
    output logic              wen_clear
);

    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - SLOT_W;

    logic [PAGE_W-1:0] page_q;
    logic              take_start;
    logic              take_byte;
    logic [SLOT_W-1:0] scan_slot;
    logic              rd_loaded;
    logic              any_loaded;

    // Page number register: captured at an accepted frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)          page_q <= '0;
        else if (take_start) page_q <= start_addr[ADDR_W-1:SLOT_W];
    end

    pwb_page_buffer #(
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (take_start),
        .base_slot  (start_addr[SLOT_W-1:0]),
        .load       (take_byte),
        .load_data  (byte_data),
        .rd_slot    (scan_slot),
        .rd_data    (arr_wdata),
        .rd_loaded  (rd_loaded),
        .any_loaded (any_loaded)
    );

    pwb_commit_ctrl #(
        .PAGE_BYTES  (PAGE_BYTES),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_valid   (start_valid),
        .byte_valid    (byte_valid),
        .frame_end     (frame_end),
        .frame_aligned (frame_aligned),
        .permit        (permit),
        .any_loaded    (any_loaded),
        .rd_loaded     (rd_loaded),
        .take_start    (take_start),
        .take_byte     (take_byte),
        .scan_slot     (scan_slot),
        .arr_we        (arr_we),
        .busy          (busy),
        .wen_clear     (wen_clear)
    );

    // Array address: held page joined to the slot being scanned.
    always_comb arr_addr = {page_q, scan_slot};

endmodule

// File: rtl/pwb_checker.sv
// Module: pwb_checker
// Port-level properties of pwb_page_commit, attached by bind.
// Assumes: synchronous active-low reset.
module pwb_checker #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    localparam int SLOT_W    = $clog2(PAGE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_end,
    input logic              frame_aligned,
    input logic              permit,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [DATA_W-1:0] arr_wdata,
    input logic              busy,
    input logic              wen_clear
);

    // R7: array writes only inside a busy interval.
    p_we_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R7: busy starts only after an aligned, permitted frame end.
    p_busy_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(frame_end && frame_aligned && permit));

    // R5: a misaligned frame end leaves an idle block idle.
    p_misaligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !frame_aligned && !busy) |=> !busy);

    // R6: a refused frame end leaves an idle block idle.
    p_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !permit && !busy) |=> !busy);

    // R4: back-to-back writes step through consecutive slots.
    p_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |->
            (arr_addr[SLOT_W-1:0] == $past(arr_addr[SLOT_W-1:0]) + 1'b1));

    // R8: the enable-clear pulse lasts one cycle and falls with busy.
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wen_clear |=> (!wen_clear && !busy));

    // R8: busy never ends without the enable-clear pulse.
    p_fall_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wen_clear));

endmodule

bind pwb_page_commit pwb_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_end     (frame_end),
    .frame_aligned (frame_aligned),
    .permit        (permit),
    .arr_we        (arr_we),
    .arr_addr      (arr_addr),
    .arr_wdata     (arr_wdata),
    .busy          (busy),
    .wen_clear     (wen_clear)
);

// File: tb/pwb_page_commit_test.sv
// Bench: scoreboard for pwb_page_commit. A driver task predicts the array
// writes of each frame and queues them. A monitor pops them as they appear.
module pwb_page_commit_test;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;
    localparam int PAGE   = 32;
    localparam int BUSYC  = 20;
    localparam int TOTAL  = PAGE + BUSYC;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_valid = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              byte_valid = 1'b0;
    logic [DATA_W-1:0] byte_data = '0;
    logic              frame_end = 1'b0;
    logic              frame_aligned = 1'b0;
    logic              permit = 1'b0;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_wdata;
    logic              busy;
    logic              wen_clear;

    int tests = 0;
    int fails = 0;
    logic [ADDR_W-1:0] q_addr [$];
    logic [DATA_W-1:0] q_data [$];
    string             q_tag  [$];
    string             cur_tag = "R1";
    int                busy_run = 0;
    bit                busy_seen = 1'b0;
    bit                done = 1'b0;

    always #2.5 clk = ~clk;

    pwb_page_commit #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W),
        .PAGE_BYTES (PAGE), .BUSY_CYCLES (BUSYC)
    ) uut (
        .clk (clk), .rst_n (rst_n),
        .start_valid (start_valid), .start_addr (start_addr),
        .byte_valid (byte_valid), .byte_data (byte_data),
        .frame_end (frame_end), .frame_aligned (frame_aligned),
        .permit (permit),
        .arr_we (arr_we), .arr_addr (arr_addr), .arr_wdata (arr_wdata),
        .busy (busy), .wen_clear (wen_clear)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each array write with the queue and time busy.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (busy) begin
                busy_run++;
                busy_seen = 1'b1;
            end
            if (arr_we) begin
                if (q_addr.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected write addr", int'(arr_addr), 0);
                end else begin
                    automatic logic [ADDR_W-1:0] ea = q_addr.pop_front();
                    automatic logic [DATA_W-1:0] ed = q_data.pop_front();
                    automatic string             et = q_tag.pop_front();
                    check(arr_addr == ea, et, "write addr", int'(arr_addr), int'(ea));
                    check(arr_wdata == ed, et, "write data", int'(arr_wdata), int'(ed));
                end
            end
            if (wen_clear)
                check(busy && busy_run == TOTAL, "R8", "wen_clear at busy cycle",
                      busy_run, TOTAL);
            if (!busy && busy_run != 0) begin
                check(busy_run == TOTAL, "R7", "busy length", busy_run, TOTAL);
                busy_run = 0;
            end
        end
    end

    // Driver: run one frame and queue the writes it should cause.
    task automatic frame(input logic [ADDR_W-1:0] addr, input int n,
                         input logic [DATA_W-1:0] seed, input bit aligned,
                         input bit perm, input bit expect_ok, input string tag);
        logic [DATA_W-1:0] slot_d [PAGE];
        bit                slot_m [PAGE];
        for (int s = 0; s < PAGE; s++) begin
            slot_m[s] = 1'b0;
            slot_d[s] = '0;
        end
        for (int i = 0; i < n; i++) begin
            automatic int s = (int'(addr[4:0]) + i) % PAGE;
            slot_d[s] = seed + DATA_W'(i * 7);
            slot_m[s] = 1'b1;
        end
        if (expect_ok && aligned && perm && n > 0)
            for (int s = 0; s < PAGE; s++)
                if (slot_m[s]) begin
                    q_addr.push_back({addr[ADDR_W-1:5], 5'(s)});
                    q_data.push_back(slot_d[s]);
                    q_tag.push_back(tag);
                end
        @(posedge clk) #1;
        start_valid = 1'b1;
        start_addr  = addr;
        @(posedge clk) #1;
        start_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_valid = 1'b1;
            byte_data  = seed + DATA_W'(i * 7);
            @(posedge clk) #1;
        end
        byte_valid    = 1'b0;
        frame_end     = 1'b1;
        frame_aligned = aligned;
        permit        = perm;
        @(posedge clk) #1;
        frame_end     = 1'b0;
        frame_aligned = 1'b0;
        permit        = 1'b0;
    endtask

    // Wait for the block to settle, then require all queued writes done.
    task automatic settle(input string tag, input bit expect_busy);
        repeat (3) @(posedge clk);
        while (busy) @(posedge clk);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(q_addr.size() == 0, tag, "pending writes", q_addr.size(), 0);
        check(busy_seen == expect_busy, tag, "busy seen", int'(busy_seen),
              int'(expect_busy));
        busy_seen = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(!busy, "R1", "busy", int'(busy), 0);
        check(!arr_we, "R1", "arr_we", int'(arr_we), 0);
        check(!wen_clear, "R1", "wen_clear", int'(wen_clear), 0);
        @(posedge clk) #1;
        rst_n = 1'b1;

        // R2: plain frame inside the page
        cur_tag = "R2";
        frame(12'h345, 4, 8'h10, 1'b1, 1'b1, 1'b1, "R2");
        settle("R2", 1'b1);

        // R2/R4: wrap past slot 31, committed in ascending slot order
        cur_tag = "R4";
        frame(12'hA5E, 4, 8'h40, 1'b1, 1'b1, 1'b1, "R4");
        settle("R4", 1'b1);

        // R3: 40 bytes fold back over slots 0..7
        cur_tag = "R3";
        frame(12'h7E0, 40, 8'h01, 1'b1, 1'b1, 1'b1, "R3");
        settle("R3", 1'b1);

        // R5: misaligned frame end cancels
        cur_tag = "R5";
        frame(12'h100, 3, 8'h55, 1'b0, 1'b1, 1'b1, "R5");
        settle("R5", 1'b0);

        // R6: refused frame end cancels
        cur_tag = "R6";
        frame(12'h200, 3, 8'h66, 1'b1, 1'b0, 1'b1, "R6");
        settle("R6", 1'b0);

        // R10: empty frame
        cur_tag = "R10";
        frame(12'h300, 0, 8'h00, 1'b1, 1'b1, 1'b1, "R10");
        settle("R10", 1'b0);

        // R9: second frame during busy is dropped
        cur_tag = "R9";
        frame(12'h41F, 1, 8'h99, 1'b1, 1'b1, 1'b1, "R9");
        frame(12'h400, 3, 8'h22, 1'b1, 1'b1, 1'b0, "R9");
        check(busy, "R9", "busy during dropped frame", int'(busy), 1);
        settle("R9", 1'b1);
        // R9: a fresh frame afterwards commits only its own byte
        frame(12'h402, 1, 8'h77, 1'b1, 1'b1, 1'b1, "R9");
        settle("R9", 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule